// File: doc/BRIEF.md
# Shift and Bit-Manipulation Unit

This block is a 16-bit datapath unit for shift and bit-level work. Each cycle it may accept one operation, made of a source word, a 4-bit shift amount, a 16-bit immediate mask, a 4-bit bit index and a 3-bit operation code. It returns a result word together with a carry flag, a zero flag and a previous-bit flag.

The operations are three shifts (logical left, logical right and arithmetic right), three mask operations (AND, OR and XOR), a clear-bit operation and a test-and-set-bit operation. Test-and-set forces one chosen bit to 1 and reports the value that bit held before. The result and flags are registered, so they appear one clock after the input is marked valid, and a valid strobe appears with them. The registered outputs keep their values until the next valid input arrives.

Top module: `bitop_unit`

## Requirements
- R1: `valid_o` is high in exactly the cycle after each cycle in which `valid_i` was high. Result and flags for an input appear in that same cycle.
- R2: Opcode 3'd0 is a logical left shift of `src_i` by `shamt_i`, with zeros filling the vacated low bits. An amount of 0 returns `src_i` unchanged.
- R3: Opcode 3'd1 is a logical right shift by `shamt_i`, with zeros filling the vacated high bits.
- R4: Opcode 3'd2 is an arithmetic right shift by `shamt_i`, with copies of `src_i[15]` filling the vacated high bits.
- R5: For opcodes 3'd0, 3'd1 and 3'd2, `carry_o` is the last bit shifted out. That is `src_i[16-n]` for a left shift and `src_i[n-1]` for a right shift by n. It is 0 when n is 0.
- R6: Opcode 3'd3 gives `src_i & mask_i`, opcode 3'd4 gives `src_i | mask_i`, and opcode 3'd5 gives `src_i ^ mask_i`.
- R7: Opcode 3'd6 gives `src_i` with bit `bidx_i` forced to 0 and every other bit unchanged.
- R8: Opcode 3'd7 gives `src_i` with bit `bidx_i` forced to 1, and `prev_o` equals `src_i[bidx_i]` as it was before the operation.
- R9: `zero_o` is 1 exactly when the registered 16-bit result is zero.
- R10: `carry_o` is 0 for opcodes 3'd3 to 3'd7. `prev_o` is 0 for every opcode other than 3'd7.
- R11: When `valid_i` is low, `result_o`, `carry_o`, `zero_o` and `prev_o` keep their values and `valid_o` goes low.
- R12: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operation is valid |
| op_i | input | 3 | Operation code |
| src_i | input | 16 | Source operand |
| shamt_i | input | 4 | Shift amount |
| mask_i | input | 16 | Immediate mask for AND/OR/XOR |
| bidx_i | input | 4 | Bit index for clear and test-and-set |
| valid_o | output | 1 | Result valid |
| result_o | output | 16 | Result word |
| carry_o | output | 1 | Last bit shifted out |
| zero_o | output | 1 | Result equals zero |
| prev_o | output | 1 | Prior value of the tested bit |

## Verification
Each opcode is run against every shift amount and bit index from 0 to 15, using eight source words. The source words include all-zeros, all-ones, a lone sign bit, a lone low bit, the largest positive value and mixed patterns. The all-ones and sign-bit words separate arithmetic from logical right-shift fill. The lone low and high bits confirm that carry comes from the correct edge and from the last bit shifted out. Test-and-set runs on bits that start both set and clear, so the previous-bit flag is seen taking both values. Idle cycles with changed inputs show that the registered outputs hold.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [2:0] {
    OP_SLL  = 3'd0,
    OP_SRL  = 3'd1,
    OP_SRA  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_CLRB = 3'd6,
    OP_TSET = 3'd7
  } bitop_e;

  function automatic logic is_shift(input bitop_e op);
    return (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
  endfunction
endpackage

// File: rtl/bitop_rshift.sv
// Log-stage right shifter with a configurable fill bit
module bitop_rshift #(
  parameter int WIDTH = 17,
  parameter int AMT_W = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stage [AMT_W+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{SH{fill_i}}, stage[s][WIDTH-1:SH]} : stage[s];
  end

  assign data_o = stage[AMT_W];
endmodule

// File: rtl/bitop_shift.sv
// Shift datapath: one right shifter serves both directions through bit reversal.
// An extra guard bit catches the last bit shifted out.
module bitop_shift #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] right_in, left_ext, left_rev, sh_in, sh_out, out_rev;
  logic             fill;

  assign right_in = {src_i, 1'b0};
  assign left_ext = {1'b0, src_i};

  for (genvar b = 0; b < EXT_W; b++) begin : g_rev
    assign left_rev[b] = left_ext[EXT_W-1-b];
    assign out_rev[b]  = sh_out[EXT_W-1-b];
  end

  assign sh_in = left_i ? left_rev : right_in;
  assign fill  = arith_i & ~left_i & src_i[DATA_W-1];

  bitop_rshift #(.WIDTH(EXT_W), .AMT_W(AMT_W)) u_rshift (
    .data_i (sh_in),
    .amt_i  (amt_i),
    .fill_i (fill),
    .data_o (sh_out)
  );

  always_comb begin
    if (left_i) begin
      res_o   = out_rev[DATA_W-1:0];
      carry_o = out_rev[EXT_W-1];
    end else begin
      res_o   = sh_out[EXT_W-1:1];
      carry_o = sh_out[0];
    end
  end
endmodule

// File: rtl/bitop_logic.sv
// Mask operations and single-bit clear / test-and-set
module bitop_logic
  import bitop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  bitop_e            op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [IDX_W-1:0]  bidx_i,
  output logic [DATA_W-1:0] res_o,
  output logic              prev_o
);
  logic [DATA_W-1:0] bit_sel;

  for (genvar b = 0; b < DATA_W; b++) begin : g_dec
    assign bit_sel[b] = (bidx_i == IDX_W'(b));
  end

  always_comb begin
    prev_o = 1'b0;
    unique case (op_i)
      OP_AND:  res_o = src_i & mask_i;
      OP_OR:   res_o = src_i | mask_i;
      OP_XOR:  res_o = src_i ^ mask_i;
      OP_CLRB: res_o = src_i & ~bit_sel;
      OP_TSET: begin
        res_o  = src_i | bit_sel;
        prev_o = |(src_i & bit_sel);
      end
      default: res_o = src_i;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = $clog2(DATA_W),
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [AMT_W-1:0]  shamt_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [IDX_W-1:0]  bidx_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              prev_o
);
  bitop_e            op;
  logic [DATA_W-1:0] sh_res, lg_res, nxt_res;
  logic              sh_carry, lg_prev, nxt_carry, nxt_prev;

  assign op = bitop_e'(op_i);

  bitop_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .src_i   (src_i),
    .amt_i   (shamt_i),
    .left_i  (op == OP_SLL),
    .arith_i (op == OP_SRA),
    .res_o   (sh_res),
    .carry_o (sh_carry)
  );

  bitop_logic #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_logic (
    .op_i   (op),
    .src_i  (src_i),
    .mask_i (mask_i),
    .bidx_i (bidx_i),
    .res_o  (lg_res),
    .prev_o (lg_prev)
  );

  always_comb begin
    if (is_shift(op)) begin
      nxt_res   = sh_res;
      nxt_carry = sh_carry;
      nxt_prev  = 1'b0;
    end else begin
      nxt_res   = lg_res;
      nxt_carry = 1'b0;
      nxt_prev  = lg_prev;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
      prev_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= nxt_res;
        carry_o  <= nxt_carry;
        zero_o   <= (nxt_res == '0);
        prev_o   <= nxt_prev;
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = $clog2(DATA_W),
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] src_i,
  input logic [AMT_W-1:0]  shamt_i,
  input logic [DATA_W-1:0] mask_i,
  input logic [IDX_W-1:0]  bidx_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              zero_o,
  input logic              prev_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_valid_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (valid_o == $past(valid_i)));

  assert_shift_zero_amt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd2 && shamt_i == '0) |=> (result_o == $past(src_i) && !carry_o));

  assert_zero_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (zero_o == (result_o == '0)));

  assert_no_carry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 3'd3) |=> !carry_o);

  assert_no_prev_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 3'd7) |=> !prev_o);

  assert_clear_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd6) |=> !result_o[$past(bidx_i)]);

  assert_tset_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd7) |=> (result_o[$past(bidx_i)] && prev_o == $past(src_i[bidx_i])));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(carry_o) && $stable(prev_o) && !valid_o));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [W-1:0]  src_i = '0;
  logic [3:0]    shamt_i = '0;
  logic [W-1:0]  mask_i = '0;
  logic [3:0]    bidx_i = '0;
  logic          valid_o, carry_o, zero_o, prev_o;
  logic [W-1:0]  result_o;

  int total = 0;
  int bad = 0;

  bitop_unit uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] op, input logic [W-1:0] s, input logic [3:0] n,
                       input logic [W-1:0] m, input logic [3:0] bi,
                       output logic [W-1:0] r, output logic c, output logic p);
    r = s; c = 1'b0; p = 1'b0;
    case (op)
      3'd0: for (int k = 0; k < int'(n); k++) begin c = r[W-1]; r = {r[W-2:0], 1'b0}; end
      3'd1: for (int k = 0; k < int'(n); k++) begin c = r[0]; r = {1'b0, r[W-1:1]}; end
      3'd2: for (int k = 0; k < int'(n); k++) begin c = r[0]; r = {r[W-1], r[W-1:1]}; end
      3'd3: r = s & m;
      3'd4: r = s | m;
      3'd5: r = s ^ m;
      3'd6: r[bi] = 1'b0;
      default: begin p = s[bi]; r[bi] = 1'b1; end
    endcase
  endtask

  function automatic string res_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd6: return "R7";
      3'd7: return "R8";
      default: return "R6";
    endcase
  endfunction

  logic [W-1:0] pats [8] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h5A3C,
                             16'h7FFF, 16'h8000, 16'h0001, 16'hC3A5};

  initial begin
    logic [W-1:0] er, last_r;
    logic ec, ep, last_c, last_p;

    #(CLK_PERIOD * 2);
    @(negedge clk_i);
    check("R12 valid", W'(valid_o), '0);
    check("R12 result", result_o, '0);
    check("R12 flags", W'({carry_o, zero_o, prev_o}), '0);
    rst_ni = 1'b1;

    for (int op = 0; op < 8; op++) begin
      for (int p = 0; p < 8; p++) begin
        for (int i = 0; i < 16; i++) begin
          @(negedge clk_i);
          valid_i = 1'b1;
          op_i    = 3'(op);
          src_i   = pats[p];
          shamt_i = 4'(i);
          bidx_i  = 4'(15 - i);
          mask_i  = pats[(p + 3) % 8] ^ 16'h0F0F ^ W'(i);
          model(op_i, src_i, shamt_i, mask_i, bidx_i, er, ec, ep);
          @(negedge clk_i);
          check("R1 valid", W'(valid_o), W'(1));
          check(res_tag(3'(op)), result_o, er);
          check(op < 3 ? "R5 carry" : "R10 carry", W'(carry_o), W'(ec));
          check(op == 7 ? "R8 prev" : "R10 prev", W'(prev_o), W'(ep));
          check("R9 zero", W'(zero_o), W'(er == '0));
        end
      end
      // idle cycle with changed inputs: outputs must hold
      last_r = result_o; last_c = carry_o; last_p = prev_o;
      valid_i = 1'b0;
      op_i    = 3'(7 - op);
      src_i   = ~src_i;
      shamt_i = 4'd7;
      mask_i  = 16'hA5A5;
      @(negedge clk_i);
      @(negedge clk_i);
      check("R11 result", result_o, last_r);
      check("R11 flags", W'({carry_o, prev_o}), W'({last_c, last_p}));
      check("R11 valid", W'(valid_o), '0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule